// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block sits at the bus-facing edge of an I2C target. It watches the synchronized clock and data lines and finds start, repeated start and stop conditions. After each start it shifts in the first byte and, where the protocol needs one, a second byte. It then decides whether this target should acknowledge. The decision uses a 7-bit own address, an optional 10-bit own address, the classes of reserved addresses, and the general call with its sub-commands. When the target acknowledges, the block holds SDA low for exactly the acknowledge clock.

The rest of the target receives these results as plain control pins:
- a one-cycle match pulse, with the direction of the access latched next to it;
- one-cycle strobes for the general-call reset and reload commands;
- a level flag that stays high while a general-call transfer is open.

The lower bits of the 7-bit own address come from address-select pins. The block latches these pins at reset and again on a reload command. There is no data stream at the edge of this block, so no valid/ready handshake is involved. Everything after the addressing phase belongs to the data path, which is outside this block.

Top module: `i2c_addr_detect`

## Requirements
- R1: A START (SDA falls while SCL is high) at any point releases SDA and restarts address reception. A STOP (SDA rises while SCL is high) at any point, even mid-byte, drops the partial byte and returns to idle. In idle, clocked bytes are ignored until the next START.
- R2: Bits are sampled on SCL rising edges, MSB first. In the first byte, bits 7..1 are the address and bit 0 is the direction (1 = read, 0 = write). On a match, `rw` takes bit 0.
- R3: On an acknowledged byte, `sda_pull` rises after the SCL falling edge that ends the eighth bit. It falls after the SCL falling edge that ends the ninth clock. It is low during the eighth bit's high phase. `match` pulses for one cycle as the acknowledge begins.
- R4: The 7-bit own address is `{cfg_addr_hi, latched select bits}`. A change on `sel_pins` has no effect until reset or a reload command.
- R5: The following first bytes are never acknowledged, even when the own address equals them:
  - address 0000000 with read (start byte);
  - addresses 0000001 to 0000111 in either direction;
  - addresses 11111xx in either direction.
- R6: The first byte 0x00 (general call) is acknowledged only when `gc_en` is 1. `gc_active` is high from that acknowledge until the next START or STOP, and it never coincides with a `match` pulse.
- R7: After an acknowledged general call, the second byte is decoded as follows:
  - 0x06 is acknowledged and pulses both `gc_reset` and `gc_reload`;
  - 0x04 is acknowledged and pulses only `gc_reload`;
  - both commands re-latch `sel_pins`;
  - any other value, including a hardware call (LSB = 1), gets no acknowledge and no strobe.
- R8: When `ten_en` is 1, a first byte 11110 a9 a8 0 whose a9 a8 equal `cfg_addr10[9:8]` is acknowledged without a `match` pulse. The next byte is acknowledged only if it equals `cfg_addr10[7:0]`, and then `match` pulses with `rw` = 0.
- R9: After a full 10-bit write match, a repeated START whose first byte is 11110 a9 a8 1 with matching a9 a8 is acknowledged at once, with `match` and `rw` = 1. The same byte after a STOP is not acknowledged.
- R10: When `ten_en` is 0, no 11110xx first byte is acknowledged.
- R11: A first byte that matches no enabled address is not acknowledged. No later byte of that transfer is acknowledged either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (resolved bus) |
| cfg_addr_hi | input | 7-SEL_W | Fixed upper bits of the 7-bit own address |
| sel_pins | input | SEL_W | Address-select pins, lower bits of the 7-bit own address |
| cfg_addr10 | input | 10 | 10-bit own address |
| gc_en | input | 1 | Acknowledge the general call |
| ten_en | input | 1 | Enable 10-bit addressing |
| sda_pull | output | 1 | 1 = drive SDA low |
| match | output | 1 | One-cycle pulse: own address acknowledged |
| rw | output | 1 | Direction of the last match, 1 = read |
| gc_reset | output | 1 | One-cycle pulse: general-call reset command |
| gc_reload | output | 1 | One-cycle pulse: general-call reload command |
| gc_active | output | 1 | General-call transfer in progress |

## Verification
The hardest case to reach is the short 10-bit read header. It only applies after a full two-byte write match, with a repeated START in between and no STOP. The bench builds exactly that sequence and then issues the same read header after a STOP to show it is refused. The address-select latch is the other hard case: it is invisible except through which address gets acknowledged. So the bench changes the pins, shows the old address still wins, issues a reload command, and then shows that the new address is acknowledged. Aborts are covered by placing START and STOP inside a partly shifted byte and then checking how the following bytes are handled.

// File: rtl/i2c_af_pkg.sv
package i2c_af_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR7_W  = 7;
  localparam int ADDR10_W = 10;

  localparam logic [BYTE_W-1:0] GC_CMD_RESET  = 8'h06;
  localparam logic [BYTE_W-1:0] GC_CMD_RELOAD = 8'h04;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_LSB10,
    PH_GCCMD,
    PH_HOLD
  } phase_t;

  typedef enum logic [2:0] {
    AC_GCALL,
    AC_STARTB,
    AC_RSVD,
    AC_TENHDR,
    AC_SEVEN
  } addr_class_t;
endpackage

// File: rtl/i2c_af_cond.sv
// Bus condition and clock-edge detector on the synchronized lines.
module i2c_af_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_p,
  output logic stop_p,
  output logic rise_p,
  output logic fall_p,
  output logic sda_s
);
  logic scl_q1, scl_q2, sda_q1, sda_q2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q1 <= 1'b1;
      scl_q2 <= 1'b1;
      sda_q1 <= 1'b1;
      sda_q2 <= 1'b1;
    end else begin
      scl_q1 <= scl_i;
      scl_q2 <= scl_q1;
      sda_q1 <= sda_i;
      sda_q2 <= sda_q1;
    end
  end

  // data edges only count as conditions while the clock stays high
  assign start_p = scl_q1 & scl_q2 & sda_q2 & ~sda_q1;
  assign stop_p  = scl_q1 & scl_q2 & ~sda_q2 & sda_q1;
  assign rise_p  = scl_q1 & ~scl_q2;
  assign fall_p  = ~scl_q1 & scl_q2;
  assign sda_s   = sda_q1;
endmodule

// File: rtl/i2c_af_shift.sv
// Byte shifter with acknowledge-slot tracking.
module i2c_af_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              en,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              sda_s,
  output logic [DATA_W-1:0] byte_o,
  output logic              ack_open,
  output logic              ack_close
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] INACK = CNT_W'(DATA_W + 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;

  assign ack_open  = en & fall_p & (cnt == FULL);
  assign ack_close = en & fall_p & (cnt == INACK);
  assign byte_o    = sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (en) begin
      if (rise_p && cnt < FULL) begin
        sh  <= {sh[DATA_W-2:0], sda_s};
        cnt <= cnt + CNT_W'(1);
      end else if (ack_open) begin
        cnt <= INACK;
      end else if (ack_close) begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/i2c_af_classify.sv
// Sorts a first byte into the reserved address classes.
module i2c_af_classify
  import i2c_af_pkg::*;
(
  input  logic [BYTE_W-1:0]  hdr,
  input  logic [ADDR7_W-1:0] own7,
  input  logic [1:0]         own10_hi,
  output addr_class_t        cls,
  output logic               hit7,
  output logic               hit10hi
);
  logic [ADDR7_W-1:0] addr;
  assign addr = hdr[BYTE_W-1:1];

  always_comb begin
    if (addr == '0)
      cls = hdr[0] ? AC_STARTB : AC_GCALL;
    else if (addr[6:3] == 4'b0000)
      cls = AC_RSVD;
    else if (addr[6:2] == 5'b11111)
      cls = AC_RSVD;
    else if (addr[6:2] == 5'b11110)
      cls = AC_TENHDR;
    else
      cls = AC_SEVEN;
  end

  assign hit7    = (addr == own7);
  assign hit10hi = (addr[1:0] == own10_hi);
endmodule

// File: rtl/i2c_addr_detect.sv
module i2c_addr_detect
  import i2c_af_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  input  logic [ADDR7_W-SEL_W-1:0] cfg_addr_hi,
  input  logic [SEL_W-1:0]         sel_pins,
  input  logic [ADDR10_W-1:0]      cfg_addr10,
  input  logic                     gc_en,
  input  logic                     ten_en,
  output logic                     sda_pull,
  output logic                     match,
  output logic                     rw,
  output logic                     gc_reset,
  output logic                     gc_reload,
  output logic                     gc_active
);
  logic start_p, stop_p, rise_p, fall_p, sda_s;
  logic ack_open, ack_close, shift_en;
  logic [BYTE_W-1:0] byte_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR7_W-1:0] own7;
  addr_class_t cls;
  logic hit7, hit10hi;
  phase_t phase, pend;
  logic ten_armed;

  // decision for the current acknowledge slot
  logic   ack_d, match_d, rw_d, gcset_d, gcrst_d, gcrld_d, arm_d;
  phase_t nxt_d;

  i2c_af_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .start_p(start_p), .stop_p(stop_p), .rise_p(rise_p), .fall_p(fall_p),
    .sda_s(sda_s)
  );

  assign shift_en = (phase == PH_HDR) || (phase == PH_LSB10) || (phase == PH_GCCMD);

  i2c_af_shift #(.DATA_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(start_p | stop_p), .en(shift_en),
    .rise_p(rise_p), .fall_p(fall_p), .sda_s(sda_s),
    .byte_o(byte_q), .ack_open(ack_open), .ack_close(ack_close)
  );

  assign own7 = {cfg_addr_hi, sel_q};

  i2c_af_classify u_cls (
    .hdr(byte_q), .own7(own7), .own10_hi(cfg_addr10[ADDR10_W-1:ADDR10_W-2]),
    .cls(cls), .hit7(hit7), .hit10hi(hit10hi)
  );

  always_comb begin
    ack_d   = 1'b0;
    nxt_d   = PH_HOLD;
    match_d = 1'b0;
    rw_d    = rw;
    gcset_d = 1'b0;
    gcrst_d = 1'b0;
    gcrld_d = 1'b0;
    arm_d   = ten_armed;
    case (phase)
      PH_HDR: begin
        arm_d = 1'b0;
        case (cls)
          AC_GCALL: if (gc_en) begin
            ack_d   = 1'b1;
            nxt_d   = PH_GCCMD;
            gcset_d = 1'b1;
          end
          AC_SEVEN: if (hit7) begin
            ack_d   = 1'b1;
            match_d = 1'b1;
            rw_d    = byte_q[0];
          end
          AC_TENHDR: if (ten_en && hit10hi) begin
            if (!byte_q[0]) begin
              ack_d = 1'b1;
              nxt_d = PH_LSB10;
            end else if (ten_armed) begin
              ack_d   = 1'b1;
              match_d = 1'b1;
              rw_d    = 1'b1;
              arm_d   = 1'b1;
            end
          end
          default: ;
        endcase
      end
      PH_LSB10: if (byte_q == cfg_addr10[BYTE_W-1:0]) begin
        ack_d   = 1'b1;
        match_d = 1'b1;
        rw_d    = 1'b0;
        arm_d   = 1'b1;
      end
      PH_GCCMD: begin
        if (byte_q == GC_CMD_RESET) begin
          ack_d   = 1'b1;
          gcrst_d = 1'b1;
          gcrld_d = 1'b1;
        end else if (byte_q == GC_CMD_RELOAD) begin
          ack_d   = 1'b1;
          gcrld_d = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      pend      <= PH_HOLD;
      sda_pull  <= 1'b0;
      match     <= 1'b0;
      rw        <= 1'b0;
      gc_reset  <= 1'b0;
      gc_reload <= 1'b0;
      gc_active <= 1'b0;
      ten_armed <= 1'b0;
      sel_q     <= sel_pins;
    end else begin
      match     <= 1'b0;
      gc_reset  <= 1'b0;
      gc_reload <= 1'b0;
      if (stop_p) begin
        phase     <= PH_IDLE;
        sda_pull  <= 1'b0;
        gc_active <= 1'b0;
        ten_armed <= 1'b0;
      end else if (start_p) begin
        phase     <= PH_HDR;
        sda_pull  <= 1'b0;
        gc_active <= 1'b0;
      end else if (ack_open) begin
        ten_armed <= arm_d;
        if (ack_d) begin
          sda_pull  <= 1'b1;
          pend      <= nxt_d;
          match     <= match_d;
          rw        <= rw_d;
          gc_reset  <= gcrst_d;
          gc_reload <= gcrld_d;
          if (gcset_d) gc_active <= 1'b1;
          if (gcrld_d) sel_q <= sel_pins;
        end else begin
          phase <= PH_HOLD;
        end
      end else if (ack_close) begin
        sda_pull <= 1'b0;
        phase    <= pend;
      end
    end
  end
endmodule

// File: rtl/i2c_af_checker.sv
module i2c_af_checker
  import i2c_af_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   start_p,
  input logic   stop_p,
  input logic   ack_close,
  input phase_t phase,
  input logic   sda_pull,
  input logic   match,
  input logic   gc_reset,
  input logic   gc_reload,
  input logic   gc_active
);
  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> (phase == PH_IDLE) && !sda_pull);

  p_start_hdr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p && !stop_p) |=> (phase == PH_HDR) && !sda_pull);

  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_close && !start_p && !stop_p) |=> !sda_pull);

  p_match_pull_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $rose(sda_pull));

  p_reload_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reload |-> $rose(sda_pull));

  p_reset_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |-> gc_reload);

  p_gc_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reload |-> gc_active);

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({match, gc_reload}));
endmodule

bind i2c_addr_detect i2c_af_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
  .ack_close(ack_close), .phase(phase), .sda_pull(sda_pull),
  .match(match), .gc_reset(gc_reset), .gc_reload(gc_reload),
  .gc_active(gc_active)
);

// File: tb/i2c_addr_detect_bench.sv
`timescale 1ns/1ps
module i2c_addr_detect_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [4:0] cfg_addr_hi;
  logic [1:0] sel_pins;
  logic [9:0] cfg_addr10;
  logic gc_en, ten_en;
  logic sda_pull, match, rw, gc_reset, gc_reload, gc_active;
  logic sda_bus;
  int n_chk = 0, n_bad = 0;
  int n_match = 0, n_rst = 0, n_rld = 0;

  always #5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  i2c_addr_detect u_i2c_addr_detect (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .cfg_addr_hi(cfg_addr_hi), .sel_pins(sel_pins), .cfg_addr10(cfg_addr10),
    .gc_en(gc_en), .ten_en(ten_en), .sda_pull(sda_pull), .match(match),
    .rw(rw), .gc_reset(gc_reset), .gc_reload(gc_reload), .gc_active(gc_active)
  );

  always @(posedge clk) if (rst_n) begin
    if (match) n_match <= n_match + 1;
    if (gc_reset) n_rst <= n_rst + 1;
    if (gc_reload) n_rld <= n_rld + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_c();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic stop_c();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_scl = 1'b0;
  endtask

  // early: pull during eighth high phase; late: pull after ninth fall
  task automatic send_byte(input logic [7:0] b, output logic acked,
                           output logic early, output logic late);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(Q);
      if (i == 0) early = sda_pull;
      m_scl = 1'b0;
    end
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    acked = ~sda_bus;
    m_scl = 1'b0; tick(Q);
    late = sda_pull;
  endtask

  // one addressing transfer: start, byte, stop; returns ack
  task automatic one_hdr(input logic [7:0] b, output logic acked);
    logic e, l;
    start_c();
    send_byte(b, acked, e, l);
    stop_c();
  endtask

  task automatic t_reset();
    chk("R3 reset sda_pull", sda_pull, 0);
    chk("R3 reset match", match, 0);
    chk("R6 reset gc_active", gc_active, 0);
    chk("R2 reset rw", rw, 0);
  endtask

  task automatic t_seven();
    logic a, e, l; int m0;
    m0 = n_match;
    start_c();
    send_byte(8'hA6, a, e, l);
    chk("R3 write ack", a, 1);
    chk("R3 no pull in 8th bit", e, 0);
    chk("R3 released after 9th clock", l, 0);
    chk("R3 match pulse", n_match - m0, 1);
    chk("R2 rw write", rw, 0);
    stop_c();
    one_hdr(8'hA7, a);
    chk("R2 read ack", a, 1);
    chk("R2 rw read", rw, 1);
  endtask

  task automatic t_mismatch();
    logic a, e, l; int m0;
    m0 = n_match;
    start_c();
    send_byte(8'hA4, a, e, l);
    chk("R11 other address no ack", a, 0);
    send_byte(8'hA6, a, e, l);
    chk("R11 later byte no ack", a, 0);
    stop_c();
    chk("R11 no match", n_match - m0, 0);
  endtask

  task automatic t_abort();
    logic a, e, l;
    start_c();
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    stop_c();
    chk("R1 stop mid-byte releases", sda_pull, 0);
    m_scl = 1'b0; tick(Q);
    send_byte(8'hA6, a, e, l);
    chk("R1 idle byte ignored", a, 0);
    m_scl = 1'b1; tick(Q);
    stop_c();
    start_c();
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    start_c();
    send_byte(8'hA6, a, e, l);
    chk("R1 restart mid-byte then ack", a, 1);
    stop_c();
  endtask

  task automatic t_gc();
    logic a, e, l; int r0, l0;
    gc_en = 1'b0;
    one_hdr(8'h00, a);
    chk("R6 gc disabled no ack", a, 0);
    gc_en = 1'b1;
    sel_pins = 2'b00;
    one_hdr(8'hA0, a);
    chk("R4 pins not latched", a, 0);
    r0 = n_rst; l0 = n_rld;
    start_c();
    send_byte(8'h00, a, e, l);
    chk("R6 gc ack", a, 1);
    chk("R6 gc_active high", gc_active, 1);
    send_byte(8'h04, a, e, l);
    chk("R7 reload ack", a, 1);
    chk("R7 reload strobe", n_rld - l0, 1);
    chk("R7 no reset strobe", n_rst - r0, 0);
    stop_c();
    chk("R6 gc_active cleared by stop", gc_active, 0);
    one_hdr(8'hA0, a);
    chk("R4 new address after reload", a, 1);
    one_hdr(8'hA6, a);
    chk("R4 old address dropped", a, 0);
    sel_pins = 2'b11;
    r0 = n_rst; l0 = n_rld;
    start_c();
    send_byte(8'h00, a, e, l);
    send_byte(8'h06, a, e, l);
    chk("R7 reset ack", a, 1);
    chk("R7 reset strobe", n_rst - r0, 1);
    chk("R7 reset reload strobe", n_rld - l0, 1);
    start_c();
    chk("R6 gc_active cleared by start", gc_active, 0);
    stop_c();
    r0 = n_rst; l0 = n_rld;
    start_c();
    send_byte(8'h00, a, e, l);
    send_byte(8'hA7, a, e, l);
    chk("R7 hardware call no ack", a, 0);
    chk("R7 hardware call no strobe", (n_rst - r0) + (n_rld - l0), 0);
    stop_c();
    one_hdr(8'hA6, a);
    chk("R4 restored address", a, 1);
  endtask

  task automatic t_reserved();
    logic a;
    logic [7:0] rs [6] = '{8'h01, 8'h02, 8'h07, 8'h0C, 8'hF8, 8'hFF};
    for (int i = 0; i < 6; i++) begin
      one_hdr(rs[i], a);
      chk($sformatf("R5 reserved %02h no ack", rs[i]), a, 0);
    end
    cfg_addr_hi = 5'b00001;
    one_hdr(8'h0E, a);
    chk("R5 own address in reserved range", a, 0);
    cfg_addr_hi = 5'b10100;
  endtask

  task automatic t_ten();
    logic a, e, l; int m0;
    ten_en = 1'b1;
    m0 = n_match;
    start_c();
    send_byte(8'hF4, a, e, l);
    chk("R8 header ack", a, 1);
    chk("R8 header no match", n_match - m0, 0);
    send_byte(8'hC5, a, e, l);
    chk("R8 low byte ack", a, 1);
    chk("R8 match", n_match - m0, 1);
    chk("R8 rw write", rw, 0);
    start_c();
    send_byte(8'hF5, a, e, l);
    chk("R9 read header ack", a, 1);
    chk("R9 match", n_match - m0, 2);
    chk("R9 rw read", rw, 1);
    stop_c();
    one_hdr(8'hF5, a);
    chk("R9 read header after stop no ack", a, 0);
    one_hdr(8'hF2, a);
    chk("R8 wrong msbs no ack", a, 0);
    start_c();
    send_byte(8'hF4, a, e, l);
    send_byte(8'hC4, a, e, l);
    chk("R8 wrong low byte no ack", a, 0);
    stop_c();
    ten_en = 1'b0;
    one_hdr(8'hF4, a);
    chk("R10 disabled header no ack", a, 0);
  endtask

  initial begin
    cfg_addr_hi = 5'b10100;
    sel_pins    = 2'b11;
    cfg_addr10  = 10'b10_1100_0101;
    gc_en       = 1'b1;
    ten_en      = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_seven();
    t_mismatch();
    t_abort();
    t_gc();
    t_reserved();
    t_ten();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule